// File: doc/BRIEF.md
# Coprocessor Mailbox Command Responder

This block is the device side of a host-to-coprocessor mailbox. A host reaches it through a plain 32-bit register port. The port holds a control word, one inbound and one outbound mailbox, and a five-word message area. The host fills the message area with a command packet and rings the inbound mailbox. After a fixed, configurable latency the block checks the packet and overwrites the message area with a response packet. It then posts a result code in the outbound mailbox. The host reads the response and clears the outbound mailbox to end the exchange.

A packet has five words: header, command, argument count, argument 0 and checksum. Three commands are recognised. The info command returns a constant information word. The refresh and vendor commands return a typed pointer word. The pointer's top nibble names the memory that its 28-bit offset refers to. The control word can hold the responder in reset or gate its clock; in either case the mailboxes stay cleared and rings are dropped.

Register writes take effect at the clock edge on which `wr_en` is sampled high. Reads are combinational from `addr`. The register port has no back-pressure: every write is accepted in one cycle, and a write that the current state forbids is simply dropped.

Top module: `mbx_responder`

## Requirements
- R1: After reset the control word (byte offset 0x0) reads 0x5, meaning held in reset (bit 0) and clock gated (bit 2). The inbound mailbox (0x14 is outbound, 0x10 is inbound) and all five message words (0x100 + 4*i) read 0.
- R2: Message words written by the host at 0x100 + 4*i read back unchanged while no response is being committed.
- R3: While control bit 0 or bit 2 is set, a write to the inbound mailbox is ignored and both mailboxes read 0. Clearing both bits releases the responder with both mailboxes at 0.
- R4: A nonzero write to the inbound mailbox starts a transaction. The outbound mailbox reads 0 for RESP_LAT cycles after that write edge and holds the result code from the (RESP_LAT+1)-th edge on. The inbound mailbox then reads 0.
- R5: A valid command returns result 0x1. The response packet is header 2, the command echoed, argument count 1, the payload, and a checksum equal to the 32-bit wrapping sum of the first four response words.
- R6: Command 1 with argument 1 (count 1) returns INFO_WORD as the payload.
- R7: Command 2 with argument 1 returns a pointer with type 1 in bits [31:28] and REFRESH_OFS in bits [27:0]. Command 2 with argument 2 returns type 0 with VENDOR_OFS.
- R8: Checks run in a fixed order, and the first failure sets the code. A header other than 1 gives 0x80000001. Then a checksum that differs from the wrapping sum of words 0..3 gives 0x80000004. Then an argument count other than 1 gives 0x80000008. Then any unknown command/argument pair gives 0x80000002.
- R9: A failed command's response packet is header 2, the command echoed, count 0, argument 0 and a recomputed checksum.
- R10: Writing 0 to the outbound mailbox clears it. Nonzero host writes to it are ignored. A ring while the outbound mailbox is nonzero is ignored and leaves the message area untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |

## Verification
A wrong internal state in this block shows up at the ports within a single exchange. A stuck busy flag or a wrong latency count moves the cycle in which the outbound code appears, and the bench checks that cycle to the exact edge. A wrong validation order or a wrong payload select shows up as the wrong result code, or as a response word that differs from the value the bench computes from the request. A gating fault shows up as a nonzero mailbox while the control word still holds the responder. A missed acknowledge shows up as a code that survives the clearing write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef logic [31:0] word_t;

  localparam int unsigned PKT_WORDS = 5;

  localparam word_t HDR_REQ = 32'd1;
  localparam word_t HDR_RSP = 32'd2;

  localparam word_t RC_OK      = 32'h0000_0001;
  localparam word_t RC_BAD_HDR = 32'h8000_0001;
  localparam word_t RC_BAD_CMD = 32'h8000_0002;
  localparam word_t RC_BAD_SUM = 32'h8000_0004;
  localparam word_t RC_BAD_FMT = 32'h8000_0008;
endpackage

// File: rtl/mbx_pkt_check.sv
module mbx_pkt_check
  import mbx_pkg::*;
#(
  parameter logic [31:0] INFO_WORD   = 32'h0102_0304,
  parameter logic [31:0] REFRESH_PTR = 32'h1000_0010,
  parameter logic [31:0] VENDOR_PTR  = 32'h0000_0040
) (
  input  logic [PKT_WORDS-1:0][31:0] req_i,
  output word_t                      code_o,
  output logic [PKT_WORDS-1:0][31:0] rsp_o
);
  word_t req_sum;
  word_t payload;
  logic  ok;

  always_comb begin
    req_sum = req_i[0] + req_i[1] + req_i[2] + req_i[3];
    payload = '0;
    ok      = 1'b0;
    // Fixed priority: header, checksum, count, then command/argument pair.
    if (req_i[0] != HDR_REQ)      code_o = RC_BAD_HDR;
    else if (req_sum != req_i[4]) code_o = RC_BAD_SUM;
    else if (req_i[2] != 32'd1)   code_o = RC_BAD_FMT;
    else begin
      code_o = RC_OK;
      ok     = 1'b1;
      if (req_i[1] == 32'd1 && req_i[3] == 32'd1)      payload = INFO_WORD;
      else if (req_i[1] == 32'd2 && req_i[3] == 32'd1) payload = REFRESH_PTR;
      else if (req_i[1] == 32'd2 && req_i[3] == 32'd2) payload = VENDOR_PTR;
      else begin
        code_o = RC_BAD_CMD;
        ok     = 1'b0;
      end
    end
    rsp_o[0] = HDR_RSP;
    rsp_o[1] = req_i[1];
    rsp_o[2] = ok ? 32'd1 : 32'd0;
    rsp_o[3] = payload;
    rsp_o[4] = rsp_o[0] + rsp_o[1] + rsp_o[2] + rsp_o[3];
  end
endmodule

// File: rtl/mbx_resp_timer.sv
module mbx_resp_timer #(
  parameter int unsigned LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int unsigned CW = (LAT > 0) ? $clog2(LAT + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign fire = busy && (cnt == '0);

  assert_fire_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy);
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !clr) |=> busy);
endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned RESP_LAT    = 3,
  parameter logic [31:0] INFO_WORD   = 32'h0102_0304,
  parameter logic [27:0] REFRESH_OFS = 28'h010,
  parameter logic [27:0] VENDOR_OFS  = 28'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int unsigned CTRL_OFS = 'h000;
  localparam int unsigned INB_OFS  = 'h010;
  localparam int unsigned OUTB_OFS = 'h014;
  localparam int unsigned MSG_BASE = 'h100;
  localparam logic [31:0] CTRL_RST = 32'h0000_0005;
  localparam logic [31:0] REF_PTR  = {4'h1, REFRESH_OFS};
  localparam logic [31:0] VEN_PTR  = {4'h0, VENDOR_OFS};

  logic [31:0]                ctrl_q;
  word_t                      inb_q;
  word_t                      outb_q;
  logic [PKT_WORDS-1:0][31:0] msg_q;
  logic [PKT_WORDS-1:0][31:0] rsp;
  word_t                      code;
  logic                       active;
  logic                       busy;
  logic                       fire;
  logic                       commit;
  logic                       ring;
  logic                       wr_ctrl;
  logic                       wr_inb;
  logic                       wr_outb;

  assign active  = !ctrl_q[0] && !ctrl_q[2];
  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_OFS));
  assign wr_inb  = wr_en && (addr == ADDR_W'(INB_OFS));
  assign wr_outb = wr_en && (addr == ADDR_W'(OUTB_OFS));
  assign ring    = wr_inb && (wdata != '0) && active && !busy && (outb_q == '0);
  assign commit  = fire && active;

  mbx_resp_timer #(.LAT(RESP_LAT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .start (ring),
    .busy  (busy),
    .fire  (fire)
  );

  mbx_pkt_check #(
    .INFO_WORD   (INFO_WORD),
    .REFRESH_PTR (REF_PTR),
    .VENDOR_PTR  (VEN_PTR)
  ) u_check (
    .req_i  (msg_q),
    .code_o (code),
    .rsp_o  (rsp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      inb_q  <= '0;
      outb_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (!active) begin
        inb_q  <= '0;
        outb_q <= '0;
      end else begin
        if (commit)    inb_q <= '0;
        else if (ring) inb_q <= wdata;
        if (commit)                         outb_q <= code;
        else if (wr_outb && wdata == '0)    outb_q <= '0;
      end
    end
  end

  for (genvar i = 0; i < PKT_WORDS; i++) begin : g_msg
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(MSG_BASE + 4 * i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      msg_q[i] <= '0;
      else if (commit) msg_q[i] <= rsp[i];
      else if (hit)    msg_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_OFS)) rdata = ctrl_q;
    if (addr == ADDR_W'(INB_OFS))  rdata = inb_q;
    if (addr == ADDR_W'(OUTB_OFS)) rdata = outb_q;
    for (int i = 0; i < PKT_WORDS; i++)
      if (addr == ADDR_W'(MSG_BASE + 4 * i)) rdata = msg_q[i];
  end

  assert_gated_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (outb_q == '0 && inb_q == '0));
  assert_code_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (outb_q != '0) |-> (outb_q == RC_OK ||
      (outb_q[31] && outb_q[30:4] == '0 && $countones(outb_q[3:0]) == 1)));
  assert_rsp_packet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (msg_q[0] == HDR_RSP &&
                msg_q[4] == msg_q[0] + msg_q[1] + msg_q[2] + msg_q[3]));
  assert_no_ring_when_posted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && outb_q != '0 && !busy) |=> (inb_q == '0 && !busy));
endmodule

// File: tb/mbx_responder_tb.sv
module mbx_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam logic [31:0] INFO = 32'hA1B2_C3D4;
  localparam logic [27:0] RFO  = 28'h0000_020;
  localparam logic [27:0] VNO  = 28'h0000_1C0;
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_IN   = 12'h010;
  localparam logic [11:0] A_OUT  = 12'h014;
  localparam logic [11:0] A_MSG  = 12'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_responder #(
    .ADDR_W(12), .RESP_LAT(LAT), .INFO_WORD(INFO),
    .REFRESH_OFS(RFO), .VENDOR_OFS(VNO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic load(logic [31:0] h, logic [31:0] c, logic [31:0] n,
                      logic [31:0] a0, logic [31:0] s);
    wr(A_MSG + 12'h0, h);
    wr(A_MSG + 12'h4, c);
    wr(A_MSG + 12'h8, n);
    wr(A_MSG + 12'hC, a0);
    wr(A_MSG + 12'h10, s);
  endtask

  // Full exchange: ring, wait the latency, check code and response packet, ack.
  task automatic exchange(string req, logic [31:0] h, logic [31:0] c, logic [31:0] n,
                          logic [31:0] a0, logic [31:0] s,
                          logic [31:0] exp_code, logic [31:0] exp_cnt, logic [31:0] exp_a0);
    logic [31:0] v;
    load(h, c, n, a0, s);
    wr(A_IN, 32'd1);
    for (int k = 1; k <= LAT; k++) @(negedge clk);
    @(negedge clk);
    rd(A_OUT, v); chk(req, "result code", v, exp_code);
    rd(A_IN, v);  chk("R4", "inbound cleared", v, 32'd0);
    rd(A_MSG + 12'h0, v);  chk(req, "rsp header", v, 32'd2);
    rd(A_MSG + 12'h4, v);  chk(req, "rsp command", v, c);
    rd(A_MSG + 12'h8, v);  chk(req, "rsp count", v, exp_cnt);
    rd(A_MSG + 12'hC, v);  chk(req, "rsp arg0", v, exp_a0);
    rd(A_MSG + 12'h10, v); chk(req, "rsp checksum", v, 32'd2 + c + exp_cnt + exp_a0);
    wr(A_OUT, 32'd0);
    rd(A_OUT, v); chk("R10", "ack clears outbound", v, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1", "ctrl reset", v, 32'h5);
    rd(A_IN, v);   chk("R1", "inbound reset", v, 32'h0);
    rd(A_OUT, v);  chk("R1", "outbound reset", v, 32'h0);
    for (int i = 0; i < 5; i++) begin
      rd(A_MSG + 12'(4 * i), v); chk("R1", "msg reset", v, 32'h0);
    end
  endtask

  task automatic t_gated;
    logic [31:0] v;
    load(1, 1, 1, 1, 4);
    wr(A_IN, 32'd1);
    repeat (LAT + 4) @(negedge clk);
    rd(A_IN, v);  chk("R3", "inbound while reset", v, 32'd0);
    rd(A_OUT, v); chk("R3", "outbound while reset", v, 32'd0);
    rd(A_MSG + 12'h0, v); chk("R3", "msg untouched while reset", v, 32'd1);
    wr(A_CTRL, 32'h4);
    wr(A_IN, 32'd1);
    repeat (LAT + 4) @(negedge clk);
    rd(A_OUT, v); chk("R3", "outbound while clock gated", v, 32'd0);
    wr(A_CTRL, 32'h0);
    rd(A_IN, v);  chk("R3", "inbound after release", v, 32'd0);
    rd(A_OUT, v); chk("R3", "outbound after release", v, 32'd0);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    wr(A_MSG + 12'h8, 32'hDEAD_BEEF);
    rd(A_MSG + 12'h8, v); chk("R2", "msg readback", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    load(1, 1, 1, 1, 4);
    wr(A_IN, 32'd1);
    for (int k = 1; k <= LAT; k++) begin
      rd(A_OUT, v); chk("R4", "outbound before latency", v, 32'd0);
      @(negedge clk);
    end
    rd(A_OUT, v); chk("R4", "outbound before latency", v, 32'd0);
    @(negedge clk);
    rd(A_OUT, v); chk("R4", "outbound at latency", v, 32'd1);
    wr(A_OUT, 32'd0);
  endtask

  task automatic t_ignore_when_posted;
    logic [31:0] v;
    load(1, 1, 1, 1, 4);
    wr(A_IN, 32'd1);
    repeat (LAT + 2) @(negedge clk);
    wr(A_MSG + 12'h0, 32'd7);
    wr(A_IN, 32'd1);
    repeat (LAT + 3) @(negedge clk);
    rd(A_IN, v);  chk("R10", "ring ignored inbound", v, 32'd0);
    rd(A_MSG + 12'h0, v); chk("R10", "msg not rewritten", v, 32'd7);
    wr(A_OUT, 32'h55);
    rd(A_OUT, v); chk("R10", "nonzero host write ignored", v, 32'd1);
    wr(A_OUT, 32'd0);
    rd(A_OUT, v); chk("R10", "outbound cleared", v, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gated();
    t_readback();
    t_latency();
    exchange("R6", 1, 1, 1, 1, 4, 32'h1, 1, INFO);
    exchange("R7", 1, 2, 1, 1, 5, 32'h1, 1, {4'h1, RFO});
    exchange("R7", 1, 2, 1, 2, 6, 32'h1, 1, {4'h0, VNO});
    exchange("R5", 1, 1, 1, 1, 4, 32'h1, 1, INFO);
    // R8 priority cases; R9 error packet shape
    exchange("R8", 3, 1, 1, 1, 99, 32'h8000_0001, 0, 0);
    exchange("R8", 1, 1, 1, 1, 5, 32'h8000_0004, 0, 0);
    exchange("R8", 1, 9, 2, 1, 13, 32'h8000_0008, 0, 0);
    exchange("R8", 1, 1, 1, 2, 5, 32'h8000_0002, 0, 0);
    exchange("R9", 1, 3, 1, 1, 6, 32'h8000_0002, 0, 0);
    exchange("R9", 1, 32'hFFFF_FFFF, 1, 1, 32'd2, 32'h8000_0002, 0, 0);
    t_ignore_when_posted();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule